// File: doc/BRIEF.md
# Sync-Qualified Two-Lane Pixel Deserializer

This block takes a serial video stream made of two data lanes, a control lane and a forwarded bit clock. It runs directly off that forwarded clock, so it follows whatever bit rate the sender uses and needs no rate setting. Each lane is shifted in one bit per clock. The control lane is searched for a programmable 7-bit alignment pattern. Once that pattern has been seen, the block knows where each 7-bit symbol starts.

After alignment, each symbol period is classified by its control symbol. A symbol equal to the programmable data pattern marks valid pixel data. The two lane symbols are joined into one 14-bit pixel, and each pair of pixels is packed into a 32-bit word for a capture FIFO. Any other control symbol discards the lane data. A pixel left alone at the end of a data run is written on its own. Loss of alignment is detected, and words that meet a full FIFO are dropped and recorded in a sticky flag.

Top module: `lane_pair_deser`

## Requirements
- R1: On each rising edge of `clk`, one bit is taken from each of `lane0_bit`, `lane1_bit` and `ctl_bit`, and each symbol is sent most significant bit first.
- R2: While unlocked, `locked` rises on the edge after the last seven control-lane bits equal `sync_pat`. From then on, a symbol boundary falls every seven bits after that match. No word is written while unlocked.
- R3: A boundary whose control symbol equals `data_pat` yields a pixel. The lane 0 symbol forms pixel bits [13:7] and the lane 1 symbol forms bits [6:0].
- R4: The first pixel of a pair goes in word bits [13:0] and the second in bits [29:16]. Bits [15:14] and [31:30] are zero.
- R5: A boundary whose control symbol is not `data_pat` writes no pixel data, whatever is on the data lanes.
- R6: A non-data boundary that follows an odd number of data symbols writes the held pixel in bits [13:0], with bits [31:14] zero.
- R7: While locked, three consecutive boundaries whose control symbol matches neither `sync_pat` nor `data_pat` clear `locked`. A matching boundary restarts that count.
- R8: A word that is due while `fifo_full` is high is not written, and `overflow` is set. `overflow` stays set until reset.
- R9: While `rst` is high, and in the cycle after it, `wr_en`, `locked` and `overflow` are low.
- R10: `wr_en` is registered and is high for exactly one cycle per word, with `wr_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Forwarded bit clock from the sender |
| rst | input | 1 | Synchronous active-high reset |
| lane0_bit | input | 1 | Serial data lane 0 (upper half of pixel) |
| lane1_bit | input | 1 | Serial data lane 1 (lower half of pixel) |
| ctl_bit | input | 1 | Serial control/sync lane |
| sync_pat | input | 7 | Control symbol that sets alignment |
| data_pat | input | 7 | Control symbol that marks pixel data |
| fifo_full | input | 1 | Capture FIFO cannot accept a word |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 32 | Packed pixel pair |
| locked | output | 1 | Symbol alignment held |
| overflow | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
The main stream pattern mixes idle, sync and data runs of even and odd length. Even runs produce full words and odd runs produce flushed half words, so the test separates correct pair packing from a flush that is missing or extra. The lane values differ in every symbol and use all-ones and near-zero values, which exposes swapped lanes, swapped pixel halves and bit-order mistakes. Further sequences check the lock conditions: idle-only streams must never lock, a changed alignment pattern must be honoured, and an interleaved sync must reset the mismatch count. A held-full FIFO run separates a dropped word from a delayed one.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef struct packed {
    logic strobe;
    logic is_data;
  } bnd_evt_t;
endpackage

// File: rtl/bit_shifter.sv
module bit_shifter #(
  parameter int SYM_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [SYM_W-1:0] sym
);
  always_ff @(posedge clk) begin
    if (rst) sym <= '0;
    else     sym <= {sym[SYM_W-2:0], din};
  end
endmodule

// File: rtl/sym_framer.sv
module sym_framer
  import deser_pkg::*;
#(
  parameter int SYM_W      = 7,
  parameter int MISS_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] ctl_sym,
  input  logic [SYM_W-1:0] sync_pat,
  input  logic [SYM_W-1:0] data_pat,
  output logic             locked,
  output bnd_evt_t         evt
);
  localparam int CNT_W  = (SYM_W > 1) ? $clog2(SYM_W) : 1;
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(SYM_W - 1);
  localparam logic [MISS_W-1:0] LAST_MISS = MISS_W'(MISS_LIMIT - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [MISS_W-1:0] miss_cnt;
  logic hit_sync, hit_data, at_bnd;

  assign hit_sync = (ctl_sym == sync_pat);
  assign hit_data = (ctl_sym == data_pat);
  assign at_bnd   = locked && (bit_cnt == LAST_BIT);

  assign evt.strobe  = at_bnd;
  assign evt.is_data = at_bnd && hit_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      bit_cnt  <= '0;
      miss_cnt <= '0;
    end else if (!locked) begin
      bit_cnt  <= '0;
      miss_cnt <= '0;
      if (hit_sync) locked <= 1'b1;
    end else if (at_bnd) begin
      bit_cnt <= '0;
      if (hit_sync || hit_data) begin
        miss_cnt <= '0;
      end else if (miss_cnt == LAST_MISS) begin
        miss_cnt <= '0;
        locked   <= 1'b0;
      end else begin
        miss_cnt <= miss_cnt + 1'b1;
      end
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pair_packer.sv
module pair_packer
  import deser_pkg::*;
#(
  parameter int PIX_W  = 14,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  bnd_evt_t          evt,
  input  logic [PIX_W-1:0]  pixel,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              overflow
);
  localparam int HALF_W = WORD_W / 2;

  logic [PIX_W-1:0]  held;
  logic              half;
  logic              emit;
  logic [WORD_W-1:0] word;

  assign emit = evt.strobe && half;

  always_comb begin
    word = '0;
    word[PIX_W-1:0] = held;
    if (evt.is_data) word[HALF_W +: PIX_W] = pixel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_data  <= '0;
      overflow <= 1'b0;
      held     <= '0;
      half     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (emit) begin
        if (fifo_full) begin
          overflow <= 1'b1;
        end else begin
          wr_en   <= 1'b1;
          wr_data <= word;
        end
      end
      if (evt.is_data) begin
        half <= !half;
        if (!half) held <= pixel;
      end else if (evt.strobe) begin
        half <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lane_pair_deser.sv
module lane_pair_deser
  import deser_pkg::*;
#(
  parameter int SYM_W      = 7,
  parameter int WORD_W     = 32,
  parameter int MISS_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lane0_bit,
  input  logic              lane1_bit,
  input  logic              ctl_bit,
  input  logic [SYM_W-1:0]  sync_pat,
  input  logic [SYM_W-1:0]  data_pat,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              locked,
  output logic              overflow
);
  localparam int N_SHIFT = 3;
  localparam int PIX_W   = 2 * SYM_W;

  logic [N_SHIFT-1:0] serial_in;
  logic [SYM_W-1:0]   syms [N_SHIFT];
  logic [PIX_W-1:0]   pixel;
  bnd_evt_t           evt;

  assign serial_in = {ctl_bit, lane1_bit, lane0_bit};

  for (genvar g = 0; g < N_SHIFT; g++) begin : g_shift
    bit_shifter #(.SYM_W(SYM_W)) u_shift (
      .clk (clk),
      .rst (rst),
      .din (serial_in[g]),
      .sym (syms[g])
    );
  end

  assign pixel = {syms[0], syms[1]};

  sym_framer #(.SYM_W(SYM_W), .MISS_LIMIT(MISS_LIMIT)) u_framer (
    .clk      (clk),
    .rst      (rst),
    .ctl_sym  (syms[2]),
    .sync_pat (sync_pat),
    .data_pat (data_pat),
    .locked   (locked),
    .evt      (evt)
  );

  pair_packer #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_packer (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .pixel     (pixel),
    .fifo_full (fifo_full),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .overflow  (overflow)
  );
endmodule

// File: rtl/lane_pair_deser_chk.sv
module lane_pair_deser_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_full,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              locked,
  input logic              overflow
);
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[31:30] == 2'b00 && wr_data[15:14] == 2'b00));

  p_no_write_full_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(fifo_full));

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_write_needs_lock_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(locked));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (!wr_en && !locked && !overflow));
endmodule

bind lane_pair_deser lane_pair_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fifo_full (fifo_full),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .locked    (locked),
  .overflow  (overflow)
);

// File: tb/lane_pair_deser_test.sv
module lane_pair_deser_test;
  localparam logic [6:0] SYNC_A = 7'h58;
  localparam logic [6:0] SYNC_B = 7'h6A;
  localparam logic [6:0] DATA_P = 7'h27;
  localparam logic [6:0] IDLE_P = 7'h00;
  localparam int NSEQ = 10;
  // each entry: {control symbol, lane0 symbol, lane1 symbol}
  localparam logic [20:0] SEQ [NSEQ] = '{
    {IDLE_P, 7'h00, 7'h00}, {IDLE_P, 7'h00, 7'h00}, {SYNC_A, 7'h00, 7'h00},
    {DATA_P, 7'h11, 7'h22}, {DATA_P, 7'h33, 7'h44}, {DATA_P, 7'h55, 7'h66},
    {SYNC_A, 7'h00, 7'h00}, {DATA_P, 7'h0A, 7'h0B}, {DATA_P, 7'h7F, 7'h01},
    {IDLE_P, 7'h3C, 7'h3C}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic lane0_bit = 1'b0, lane1_bit = 1'b0, ctl_bit = 1'b0, fifo_full = 1'b0;
  logic [6:0] sync_pat = SYNC_A, data_pat = DATA_P;
  logic wr_en, locked, overflow;
  logic [31:0] wr_data;

  int checks = 0, failures = 0, ncap = 0;
  logic [31:0] cap [16];
  logic prev_wr = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_pair_deser uut (
    .clk(clk), .rst(rst), .lane0_bit(lane0_bit), .lane1_bit(lane1_bit),
    .ctl_bit(ctl_bit), .sync_pat(sync_pat), .data_pat(data_pat),
    .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data),
    .locked(locked), .overflow(overflow)
  );

  function automatic logic [13:0] pix(input logic [6:0] a, input logic [6:0] b);
    return {a, b};
  endfunction

  function automatic logic [31:0] pack(input logic [13:0] lo, input logic [13:0] hi);
    return {2'b00, hi, 2'b00, lo};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [6:0] c, input logic [6:0] a, input logic [6:0] b);
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      ctl_bit = c[i]; lane0_bit = a[i]; lane1_bit = b[i];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ctl_bit = 0; lane0_bit = 0; lane1_bit = 0; fifo_full = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ncap = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    ctl_bit = 0; lane0_bit = 0; lane1_bit = 0;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (ncap < 16) cap[ncap] = wr_data;
      ncap++;
    end
    if (!rst && prev_wr && wr_en) chk(1'b0, "R10 back-to-back wr_en", 32'd1, 32'd0);
    prev_wr = wr_en && !rst;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    // R9: reset state
    repeat (2) @(negedge clk);
    chk(!wr_en && !locked && !overflow, "R9 in reset",
        {29'd0, wr_en, locked, overflow}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_en && !locked && !overflow, "R9 after reset",
        {29'd0, wr_en, locked, overflow}, 32'd0);

    // Table walk: R1 R3 R4 R5 R6, then continue with idles for R7
    for (int k = 0; k < NSEQ; k++) send(SEQ[k][20:14], SEQ[k][13:7], SEQ[k][6:0]);
    send(IDLE_P, 7'h12, 7'h34);
    send(IDLE_P, 7'h56, 7'h78);
    settle();
    chk(ncap == 3, "R5 word count (idle data discarded)", ncap, 3);
    w = pack(pix(7'h11, 7'h22), pix(7'h33, 7'h44));
    chk(cap[0] == w, "R3 R4 first pair", cap[0], w);
    w = pack(pix(7'h55, 7'h66), 14'd0);
    chk(cap[1] == w, "R6 odd-run flush", cap[1], w);
    w = pack(pix(7'h0A, 7'h0B), pix(7'h7F, 7'h01));
    chk(cap[2] == w, "R1 R4 second pair", cap[2], w);
    chk(!locked, "R7 unlock after three misses", locked, 0);

    // R7: a sync between misses keeps lock; R6 single pixel flush
    do_reset();
    send(SYNC_A, 0, 0);
    send(IDLE_P, 0, 0); send(IDLE_P, 0, 0);
    send(SYNC_A, 0, 0);
    send(IDLE_P, 0, 0); send(IDLE_P, 0, 0);
    send(DATA_P, 7'h40, 7'h3F);
    send(IDLE_P, 7'h7F, 7'h7F);
    settle();
    chk(locked, "R7 miss count restarted by sync", locked, 1);
    w = pack(pix(7'h40, 7'h3F), 14'd0);
    chk(ncap == 1 && cap[0] == w, "R6 lone pixel flush", cap[0], w);

    // R8: full FIFO drops, overflow sticky
    do_reset();
    send(SYNC_A, 0, 0);
    fifo_full = 1'b1;
    send(DATA_P, 7'h01, 7'h02);
    send(DATA_P, 7'h03, 7'h04);
    send(DATA_P, 7'h05, 7'h06);
    fifo_full = 1'b0;
    send(DATA_P, 7'h07, 7'h08);
    send(SYNC_A, 0, 0);
    settle();
    chk(overflow, "R8 overflow set", overflow, 1);
    w = pack(pix(7'h05, 7'h06), pix(7'h07, 7'h08));
    chk(ncap == 1 && cap[0] == w, "R8 dropped word not written", cap[0], w);
    repeat (5) @(negedge clk);
    chk(overflow, "R8 overflow sticky", overflow, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(!overflow && !locked, "R9 reset clears overflow", overflow, 0);

    // R2: no lock without sync pattern
    do_reset();
    send(DATA_P, 7'h11, 7'h11); send(DATA_P, 7'h22, 7'h22);
    send(IDLE_P, 0, 0); send(DATA_P, 7'h33, 7'h33); send(DATA_P, 7'h44, 7'h44);
    settle();
    chk(!locked && ncap == 0, "R2 no lock without sync", {31'd0, locked}, 0);

    // R2: programmable sync pattern; old one ignored
    do_reset();
    sync_pat = SYNC_B;
    send(IDLE_P, 0, 0); send(SYNC_A, 0, 0); send(IDLE_P, 0, 0);
    @(negedge clk);
    chk(!locked, "R2 old sync ignored", locked, 0);
    do_reset();
    send(IDLE_P, 0, 0); send(SYNC_B, 0, 0);
    send(DATA_P, 7'h2A, 7'h55); send(DATA_P, 7'h15, 7'h6B);
    send(SYNC_B, 0, 0);
    settle();
    w = pack(pix(7'h2A, 7'h55), pix(7'h15, 7'h6B));
    chk(locked && ncap == 1 && cap[0] == w, "R2 lock on new sync", cap[0], w);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule